// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects maskable interrupt requests and presents one of them at a time to a processor core. Some requests come from external pins. Each pin passes through a three-sample noise filter and an edge detector, and a per-pin select chooses which edges count. The other requests come from internal peripherals as single-cycle pulses. Each request sets a per-source pending flag. Every source has its own mask bit and its own 3-bit priority level.

Each cycle the controller picks the best unmasked pending source. The lowest programmed level wins, and on a tie the lowest source index wins. When the winner may interrupt, the controller raises a request to the core together with the source's exception code and handler address. A one-bit-per-level in-service record remembers which levels are being handled. A new request is presented only when it beats the most urgent level in service. The core answers with a one-cycle acknowledge and, when the handler returns, with an end-of-interrupt pulse. The resume address is the core's own concern.

Top module: `prio_vic`

## Requirements
- R1: After reset `irq` is low, `ack_code` is 0, every source is masked with level 7, no flag is pending and no level is in service.
- R2: A masked source never drives `irq`. Its pending flag is kept, so it is presented once the mask bit is cleared.
- R3: Among unmasked pending sources, the one with the numerically smallest programmed level (0 most urgent, 7 least) is presented.
- R4: When several candidates share the winning level, the source with the lowest index is presented.
- R5: `irq_code` equals 0x0080 + 0x10 × source index, and `irq_vec` is that code zero-extended to 32 bits.
- R6: An `ack` while `irq` is high does three things: it clears that source's pending flag, marks its level in service, and loads `ack_code` with the presented code one cycle later. An `ack` while `irq` is low changes nothing.
- R7: While levels are in service, a request is presented only if its level is strictly smaller than the smallest level in service. Equal or larger levels wait.
- R8: An `eoi` pulse removes the smallest level in service. This can release requests that were waiting on it.
- R9: With `gie` low, `irq` stays low and pending flags are kept.
- R10: Sources 0 to N_EXT-1 are pins with a 2-bit edge select: 00 ignores all edges, 01 takes rising, 10 takes falling, 11 takes both. The select is written through `cfg_edge` and is ignored for internal sources.
- R11: A pin level is accepted only after it is seen equal on 3 consecutive clock samples, so a 2-cycle glitch is ignored. A clean rising edge on a pin, applied before clock edge 1, is presented after clock edge 5.
- R12: A one-cycle high on `int_req[j]` sets the pending flag of source N_EXT+j. A `pend_clr` clears the pending flag of the source given by `cfg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | N_EXT | External interrupt pins |
| int_req | input | N_SRC-N_EXT | Internal request pulses |
| gie | input | 1 | Global interrupt enable |
| cfg_we | input | 1 | Write mask, level and edge select of source `cfg_sel` |
| cfg_sel | input | log2(N_SRC) | Source addressed by configuration or pending clear |
| cfg_mask | input | 1 | Mask bit to write (1 = masked) |
| cfg_prio | input | PRIO_W | Priority level to write |
| cfg_edge | input | 2 | Edge select to write (pin sources only) |
| pend_clr | input | 1 | Clear pending flag of `cfg_sel` |
| ack | input | 1 | Core acknowledge, one cycle |
| eoi | input | 1 | End of interrupt, one cycle |
| irq | output | 1 | Interrupt request to the core |
| irq_code | output | 16 | Exception code of the presented source |
| irq_vec | output | 32 | Handler address of the presented source |
| ack_code | output | 16 | Code captured at the last taken acknowledge |

## Verification
A corrupted pending flag or mask bit shows up in the same cycle: `irq_code` points at the wrong source, or `irq` is present or missing when it should not be. A wrong in-service record stays hidden until a request with a lower or equal level arrives. It then shows as a request that should have been held back, or one that is wrongly blocked. A stuck record also shows up after an `eoi`, when a waiting request fails to appear. Filter and edge faults only show a few cycles after the pin moves, so the pin latency is checked on the exact cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int unsigned CODE_BASE = 32'h0080;
  localparam int unsigned CODE_STEP = 32'h0010;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // Exception code of a source: base plus a fixed stride per index.
  function automatic logic [15:0] code_of(input int unsigned idx);
    return 16'(CODE_BASE + idx * CODE_STEP);
  endfunction

  // Whether a filtered transition counts under the given edge select.
  function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
    case (sel)
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      EDGE_BOTH: return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vic_pin_filter.sv
module vic_pin_filter
  import vic_pkg::*;
#(
  parameter int STABLE = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       hit
);

  logic [STABLE-1:0] samp;
  logic              filt;
  logic              filt_d;
  logic              all_same;
  logic              rise;
  logic              fall;

  assign all_same = (samp == {STABLE{samp[0]}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp   <= '0;
      filt   <= 1'b0;
      filt_d <= 1'b0;
    end else begin
      samp   <= {samp[STABLE-2:0], pin};
      filt_d <= filt;
      if (all_same) filt <= samp[0];
    end
  end

  assign rise = filt & ~filt_d;
  assign fall = ~filt & filt_d;
  assign hit  = edge_hit(edge_sel_e'(edge_sel), rise, fall);

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  localparam int IW    = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             elig,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  output logic                         valid,
  output logic [IW-1:0]                idx,
  output logic [PRIO_W-1:0]            lvl
);

  // Strict compare keeps the lower index on equal levels.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    lvl   = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!valid || prio[i] < lvl)) begin
        valid = 1'b1;
        idx   = IW'(i);
        lvl   = prio[i];
      end
    end
  end

endmodule

// File: rtl/vic_isr_stack.sv
module vic_isr_stack #(
  parameter int PRIO_W = 3,
  localparam int N_LVL = 1 << PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_lvl,
  input  logic              pop,
  output logic [N_LVL-1:0]  active,
  output logic              top_valid,
  output logic [PRIO_W-1:0] top_lvl
);

  logic [N_LVL-1:0] nxt;

  always_comb begin
    top_valid = 1'b0;
    top_lvl   = '0;
    for (int l = N_LVL - 1; l >= 0; l--) begin
      if (active[l]) begin
        top_valid = 1'b1;
        top_lvl   = PRIO_W'(l);
      end
    end
  end

  always_comb begin
    nxt = active;
    if (pop && top_valid) nxt[top_lvl] = 1'b0;
    if (push) nxt[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) active <= '0;
    else        active <= nxt;
  end

endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import vic_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_EXT  = 2,
  parameter int PRIO_W = 3,
  parameter int STABLE = 3,
  localparam int IW    = $clog2(N_SRC),
  localparam int N_INT = N_SRC - N_EXT,
  localparam int N_LVL = 1 << PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic [N_INT-1:0]  int_req,
  input  logic              gie,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_sel,
  input  logic              cfg_mask,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [1:0]        cfg_edge,
  input  logic              pend_clr,
  input  logic              ack,
  input  logic              eoi,
  output logic              irq,
  output logic [15:0]       irq_code,
  output logic [31:0]       irq_vec,
  output logic [15:0]       ack_code
);

  logic [N_SRC-1:0]             mask_q;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [N_EXT-1:0][1:0]        edge_q;
  logic [N_SRC-1:0]             pend_q;
  logic [N_SRC-1:0]             set_w;
  logic [N_SRC-1:0]             elig_w;
  logic                         win_valid;
  logic [IW-1:0]                win_idx;
  logic [PRIO_W-1:0]            win_lvl;
  logic [N_LVL-1:0]             isr_active;
  logic                         top_valid;
  logic [PRIO_W-1:0]            top_lvl;
  logic                         nest_ok;
  logic                         take_w;

  // Request sources
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    vic_pin_filter #(.STABLE(STABLE)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin[g]),
      .edge_sel(edge_q[g]), .hit(set_w[g])
    );
  end
  for (genvar j = 0; j < N_INT; j++) begin : g_int
    assign set_w[N_EXT + j] = int_req[j];
  end

  // Configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      prio_q <= '1;
      edge_q <= '0;
    end else if (cfg_we) begin
      mask_q[cfg_sel] <= cfg_mask;
      prio_q[cfg_sel] <= cfg_prio;
      for (int e = 0; e < N_EXT; e++)
        if (cfg_sel == IW'(e)) edge_q[e] <= cfg_edge;
    end
  end

  // Pending flags: a new event wins over a clear in the same cycle
  assign take_w = ack & irq;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (set_w[i])
          pend_q[i] <= 1'b1;
        else if ((take_w && win_idx == IW'(i)) || (pend_clr && cfg_sel == IW'(i)))
          pend_q[i] <= 1'b0;
      end
    end
  end

  assign elig_w = pend_q & ~mask_q;

  vic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .elig(elig_w), .prio(prio_q),
    .valid(win_valid), .idx(win_idx), .lvl(win_lvl)
  );

  vic_isr_stack #(.PRIO_W(PRIO_W)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .push(take_w), .push_lvl(win_lvl), .pop(eoi),
    .active(isr_active), .top_valid(top_valid), .top_lvl(top_lvl)
  );

  // Request and vector
  assign nest_ok  = !top_valid || (win_lvl < top_lvl);
  assign irq      = gie & win_valid & nest_ok;
  assign irq_code = code_of(int'(win_idx));
  assign irq_vec  = {16'h0000, irq_code};

  always_ff @(posedge clk) begin
    if (!rst_n)      ack_code <= '0;
    else if (take_w) ack_code <= irq_code;
  end

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  localparam int IW    = $clog2(N_SRC),
  localparam int N_LVL = 1 << PRIO_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic             ack,
  input logic             eoi,
  input logic             irq,
  input logic [15:0]      irq_code,
  input logic [31:0]      irq_vec,
  input logic [15:0]      ack_code,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_LVL-1:0] isr_active
);

  logic [15:0] code_idx;
  assign code_idx = (irq_code - 16'h0080) >> 4;

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (code_idx < 16'(N_SRC)) && pend_q[code_idx[IW-1:0]] && !mask_q[code_idx[IW-1:0]]); // R2
  AST_VECTOR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_vec == {16'h0000, irq_code}) && (irq_code[3:0] == 4'h0) && (irq_code >= 16'h0080)); // R5
  AST_ACK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> ack_code == $past(irq_code)); // R6
  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq) |=> $stable(ack_code) && $stable(isr_active)); // R6
  AST_STACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(isr_active) <= $countones($past(isr_active)) + 1); // R7
  AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(ack && irq) && isr_active != '0) |=>
      $countones(isr_active) == $countones($past(isr_active)) - 1); // R8
  AST_GIE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq); // R9

endmodule

bind prio_vic vic_checker #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_vic_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .ack(ack), .eoi(eoi),
  .irq(irq), .irq_code(irq_code), .irq_vec(irq_vec), .ack_code(ack_code),
  .pend_q(pend_q), .mask_q(mask_q), .isr_active(isr_active)
);

// File: tb/test_prio_vic.sv
`timescale 1ns/1ps
module test_prio_vic;

  localparam int N_SRC = 8;
  localparam int N_EXT = 2;
  localparam int N_INT = N_SRC - N_EXT;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N_EXT-1:0] ext_pin;
  logic [N_INT-1:0] int_req;
  logic             gie, cfg_we, cfg_mask, pend_clr, ack, eoi;
  logic [2:0]       cfg_sel, cfg_prio;
  logic [1:0]       cfg_edge;
  logic             irq;
  logic [15:0]      irq_code, ack_code;
  logic [31:0]      irq_vec;

  int          checks = 0;
  int          errors = 0;
  logic [15:0] sb_q[$];
  logic        ack_d = 1'b0;

  always #5 clk = ~clk;

  prio_vic i_prio_vic (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .int_req(int_req), .gie(gie),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mask(cfg_mask), .cfg_prio(cfg_prio),
    .cfg_edge(cfg_edge), .pend_clr(pend_clr), .ack(ack), .eoi(eoi),
    .irq(irq), .irq_code(irq_code), .irq_vec(irq_vec), .ack_code(ack_code)
  );

  function automatic logic [15:0] exp_code(input int src);
    return 16'(128 + 16 * src);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int src, input logic m, input logic [2:0] p, input logic [1:0] e);
    cfg_we = 1'b1; cfg_sel = 3'(src); cfg_mask = m; cfg_prio = p; cfg_edge = e;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_int(input int src);
    int_req[src - N_EXT] = 1'b1;
    step(1);
    int_req = '0;
  endtask

  task automatic clr_pend(input int src);
    pend_clr = 1'b1; cfg_sel = 3'(src);
    step(1);
    pend_clr = 1'b0;
  endtask

  // Driver side of the scoreboard: the expected captured code is queued.
  task automatic do_ack(input logic [15:0] expected);
    sb_q.push_back(expected);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    step(1);
    eoi = 1'b0;
  endtask

  task automatic expect_irq(input string tag, input int src);
    chk({tag, " irq"}, 32'(irq), 32'd1);
    chk({tag, " code"}, 32'(irq_code), 32'(exp_code(src)));
  endtask

  // Monitor side: one cycle after each ack, compare the captured code.
  always @(posedge clk) ack_d <= ack;
  always @(negedge clk) begin
    if (ack_d) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R6 scoreboard empty actual=%h expected=none", ack_code);
      end else begin
        logic [15:0] e;
        e = sb_q.pop_front();
        if (ack_code !== e) begin
          errors++;
          $display("FAIL R6 ack_code actual=%h expected=%h", ack_code, e);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_pin = '0; int_req = '0; gie = 1'b1; cfg_we = 1'b0;
    cfg_sel = '0; cfg_mask = 1'b1; cfg_prio = '0; cfg_edge = '0;
    pend_clr = 1'b0; ack = 1'b0; eoi = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 ack_code", 32'(ack_code), 32'd0);

    // R2 masked request held, R12 internal pulse sets pending
    pulse_int(2);
    chk("R2 masked", 32'(irq), 32'd0);
    cfg(2, 1'b0, 3'd5, 2'b00);
    expect_irq("R2 R12 unmasked", 2);
    chk("R5 vec", irq_vec, 32'h0000_00A0);

    // R4 tie on level, R3 level wins
    cfg(3, 1'b0, 3'd5, 2'b00);
    pulse_int(3);
    expect_irq("R4 tie", 2);
    cfg(4, 1'b0, 3'd2, 2'b00);
    pulse_int(4);
    expect_irq("R3 level", 4);
    chk("R5 vec", irq_vec, 32'h0000_00C0);

    // R9 global enable
    gie = 1'b0; step(1);
    chk("R9 blocked", 32'(irq), 32'd0);
    gie = 1'b1; step(1);
    expect_irq("R9 retained", 4);

    // R6 acknowledge, R7 nesting
    do_ack(exp_code(4));
    chk("R7 lower blocked", 32'(irq), 32'd0);
    cfg(5, 1'b0, 3'd2, 2'b00);
    pulse_int(5);
    chk("R7 equal blocked", 32'(irq), 32'd0);
    cfg(6, 1'b0, 3'd1, 2'b00);
    pulse_int(6);
    expect_irq("R7 higher nests", 6);
    do_ack(exp_code(6));
    chk("R7 after nest", 32'(irq), 32'd0);

    // R8 end of interrupt
    do_eoi();
    chk("R8 level2 still active", 32'(irq), 32'd0);
    do_eoi();
    expect_irq("R8 released", 5);

    // R6 ack with irq low ignored
    gie = 1'b0;
    do_ack(exp_code(6));
    gie = 1'b1; step(1);
    expect_irq("R6 ignored ack", 5);

    // R12 software clear
    clr_pend(5);
    expect_irq("R12 cleared", 2);
    do_ack(exp_code(2));
    chk("R7 equal level waits", 32'(irq), 32'd0);
    do_eoi();
    expect_irq("R8 pop", 3);
    do_ack(exp_code(3));
    do_eoi();
    chk("R6 all taken", 32'(irq), 32'd0);

    // R10 R11 pin source 0, rising
    cfg(0, 1'b0, 3'd0, 2'b01);
    ext_pin[0] = 1'b1;
    step(4);
    chk("R11 not yet", 32'(irq), 32'd0);
    step(1);
    expect_irq("R11 R10 rise", 0);
    do_ack(exp_code(0));
    do_eoi();
    ext_pin[0] = 1'b0;
    step(8);
    chk("R10 fall ignored in rise mode", 32'(irq), 32'd0);

    // R10 falling mode
    cfg(0, 1'b0, 3'd0, 2'b10);
    ext_pin[0] = 1'b1;
    step(8);
    chk("R10 rise ignored in fall mode", 32'(irq), 32'd0);
    ext_pin[0] = 1'b0;
    step(8);
    expect_irq("R10 fall", 0);
    do_ack(exp_code(0));
    do_eoi();

    // R11 glitch of two cycles
    cfg(0, 1'b0, 3'd0, 2'b11);
    ext_pin[0] = 1'b1;
    step(2);
    ext_pin[0] = 1'b0;
    step(8);
    chk("R11 glitch", 32'(irq), 32'd0);

    // R10 both edges on source 1
    cfg(1, 1'b0, 3'd3, 2'b11);
    ext_pin[1] = 1'b1;
    step(8);
    expect_irq("R10 both rise", 1);
    do_ack(exp_code(1));
    do_eoi();
    ext_pin[1] = 1'b0;
    step(8);
    expect_irq("R10 both fall", 1);
    do_ack(exp_code(1));
    do_eoi();

    // R10 none
    cfg(1, 1'b0, 3'd3, 2'b00);
    ext_pin[1] = 1'b1;
    step(8);
    chk("R10 none", 32'(irq), 32'd0);

    step(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule